// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block is the receive half of an asynchronous serial port. It watches a line that idles high and treats a low level as a possible start bit. It confirms the start bit halfway through, then samples each data bit at its centre using an oversampling tick that the surrounding logic supplies. The character arrives least significant bit first. An optional parity bit and one or two stop bits follow it. At the end of the character the block checks the parity and the first stop bit, and it checks whether the previous character has been taken. It then decides whether to move the character into the receive data register and which flags to raise.

Software sees one receive-full flag and three sticky error flags: overrun, framing and parity. It clears each flag with its own one-cycle strobe. Two level interrupt requests come from these flags, and a single interrupt enable gates both. While any error flag is set, the receiver does not start a new character. Software must acknowledge the error before traffic resumes. Baud generation and transmit are outside this block.

Top module: `serial_rx_core`

## Requirements
- R1: The line is sampled only on cycles with `samp_en` high, at OVERSAMPLE (16) ticks per bit. A low line in idle starts a candidate start bit, which is sampled again 8 ticks later. If the line is high at that point, the candidate is dropped and no flag or data register changes.
- R2: Data bits are placed into `rx_data` least significant bit first. The character is 8 bits when `cfg_short_char` is 0 and 7 bits when it is 1. In 7-bit mode, `rx_data[7]` reads 0.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. The number of ones in the data plus the parity bit must be even when `cfg_par_odd` is 0 and odd when it is 1. On a mismatch, `err_parity` is set, `rx_data` is still loaded and `rx_full` stays 0.
- R4: A stop bit sampled as 0 sets `err_framing`. The character is still loaded into `rx_data` and `rx_full` stays 0.
- R5: With `cfg_two_stop` = 1, only the first stop bit is checked. A 0 in the second stop bit raises no flag.
- R6: If `rx_full` is 1 when a character completes, `err_overrun` is set and `rx_data` keeps the earlier character.
- R7: A character that passes every check is loaded into `rx_data` and sets `rx_full`.
- R8: `irq_rx_full` equals `rx_full` AND `irq_en`.
- R9: `irq_rx_err` is 1 exactly when `irq_en` is 1 and at least one error flag is 1.
- R10: Each error flag stays set until its own clear strobe is pulsed. A strobe for one flag leaves the other flags unchanged.
- R11: While any error flag is 1, incoming characters are not received: `rx_data` and `rx_full` do not change.
- R12: A one-cycle pulse on `clr_full` clears `rx_full`.
- R13: After reset, `rx_data`, every flag and both interrupt requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| samp_en | input | 1 | Oversampling tick, OVERSAMPLE per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_short_char | input | 1 | 1 selects characters one bit shorter than DATA_W |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | Two stop bits |
| irq_en | input | 1 | Enable for both interrupt requests |
| clr_full | input | 1 | Clear strobe for rx_full |
| clr_overrun | input | 1 | Clear strobe for err_overrun |
| clr_framing | input | 1 | Clear strobe for err_framing |
| clr_parity | input | 1 | Clear strobe for err_parity |
| rx_data | output | DATA_W | Receive data register |
| rx_full | output | 1 | Receive data register holds an unread good character |
| err_overrun | output | 1 | Sticky overrun flag |
| err_framing | output | 1 | Sticky framing flag |
| err_parity | output | 1 | Sticky parity flag |
| irq_rx_full | output | 1 | Receive-full interrupt request (level) |
| irq_rx_err | output | 1 | Receive-error interrupt request (level) |

## Verification
The assertions assume that the format controls stay steady while a character is in flight. They also assume that a clear strobe never lands in the same cycle that a character completes, because the overrun and sticky-flag properties reason about one event per cycle. The bench changes the format inputs only between frames, after the line has idled for two bit times. It pulses the clear strobes only once a frame has fully finished. Each frame is held bit by bit for exactly OVERSAMPLE ticks, so the midpoint samples always fall well inside each bit.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_STOP2
   } rx_state_e;

endpackage

// File: rtl/srx_line_sync.sv
module srx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   logic [STAGES-1:0] q;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("srx_line_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q[0] <= 1'b1;
               else        q[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) q[i] <= 1'b1;
               else        q[i] <= q[i-1];
            end
         end
      end
   endgenerate

   assign dout = q[STAGES-1];

endmodule

// File: rtl/srx_frame_fsm.sv
module srx_frame_fsm
   import srx_pkg::*;
#(
   parameter int OVERSAMPLE = 16,
   parameter int DATA_W     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              line,
   input  logic              hold,
   input  logic              cfg_short,
   input  logic              cfg_par_en,
   input  logic              cfg_two_stop,
   output logic              done,
   output logic [DATA_W-1:0] shreg,
   output logic              par_bit,
   output logic              stop_bit
);

   localparam int CNT_W = $clog2(OVERSAMPLE);
   localparam int IDX_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OVERSAMPLE / 2 - 1);
   localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(OVERSAMPLE - 1);
   localparam logic [IDX_W-1:0] IDX_LONG  = IDX_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] IDX_SHORT = IDX_W'(DATA_W - 2);

   rx_state_e        state;
   logic [CNT_W-1:0] cnt;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] last_idx;
   logic             at_mid;
   logic             at_half;

   assign last_idx = cfg_short ? IDX_SHORT : IDX_LONG;
   assign at_mid   = tick && (cnt == BIT_LAST);
   assign at_half  = tick && (cnt == HALF_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         cnt      <= '0;
         idx      <= '0;
         shreg    <= '0;
         par_bit  <= 1'b0;
         stop_bit <= 1'b1;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (tick && !hold && !line) begin
                  state <= ST_START;
                  cnt   <= '0;
               end
            end
            ST_START: begin
               if (at_half) begin
                  cnt <= '0;
                  if (!line) begin
                     state <= ST_DATA;
                     idx   <= '0;
                     shreg <= '0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (at_mid) begin
                  cnt        <= '0;
                  shreg[idx] <= line;
                  if (idx == last_idx) state <= cfg_par_en ? ST_PAR : ST_STOP;
                  else                 idx   <= idx + 1'b1;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PAR: begin
               if (at_mid) begin
                  cnt     <= '0;
                  par_bit <= line;
                  state   <= ST_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (at_mid) begin
                  cnt      <= '0;
                  stop_bit <= line;
                  done     <= 1'b1;
                  state    <= cfg_two_stop ? ST_STOP2 : ST_IDLE;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP2: begin
               if (at_mid) begin
                  cnt   <= '0;
                  state <= ST_IDLE;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // An error flag that is held keeps the receiver parked in idle.
   p_hold_parks_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE && hold) |=> (state == ST_IDLE));

   // A start candidate that is high at its midpoint is dropped without completing a character.
   p_glitch_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && at_half && line) |=> (state == ST_IDLE && !done));

   // Completion only ever comes out of the first stop bit.
   p_done_from_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(state) == ST_STOP));

endmodule

// File: rtl/srx_status_regs.sv
module srx_status_regs #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] data_in,
   input  logic              par_bit,
   input  logic              stop_bit,
   input  logic              cfg_short,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              irq_en,
   input  logic              clr_full,
   input  logic              clr_ovr,
   input  logic              clr_frm,
   input  logic              clr_par,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              err_ovr,
   output logic              err_frm,
   output logic              err_par,
   output logic              err_any,
   output logic              irq_full,
   output logic              irq_err
);

   logic [DATA_W-1:0] counted;
   logic              ones_odd;
   logic              par_bad;
   logic              frm_bad;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_mask
         if (i == DATA_W - 1) begin : g_top
            assign counted[i] = data_in[i] & ~cfg_short;
         end else begin : g_low
            assign counted[i] = data_in[i];
         end
      end
   endgenerate

   assign ones_odd = (^counted) ^ par_bit;
   assign par_bad  = cfg_par_en && (ones_odd != cfg_par_odd);
   assign frm_bad  = !stop_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data <= '0;
         rx_full <= 1'b0;
         err_ovr <= 1'b0;
         err_frm <= 1'b0;
         err_par <= 1'b0;
      end else begin
         if (clr_full) rx_full <= 1'b0;
         if (clr_ovr)  err_ovr <= 1'b0;
         if (clr_frm)  err_frm <= 1'b0;
         if (clr_par)  err_par <= 1'b0;
         if (done) begin
            if (rx_full) begin
               err_ovr <= 1'b1;
            end else begin
               rx_data <= counted;
               if (par_bad) err_par <= 1'b1;
               if (frm_bad) err_frm <= 1'b1;
               if (!par_bad && !frm_bad) rx_full <= 1'b1;
            end
         end
      end
   end

   assign err_any  = err_ovr | err_frm | err_par;
   assign irq_full = irq_en & rx_full;
   assign irq_err  = irq_en & err_any;

   // A completion while full raises overrun and leaves the data register alone.
   p_overrun_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rx_full && !clr_full) |=> (err_ovr && $stable(rx_data)));

   // The full flag rises only on a completed character.
   p_full_from_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_full) |-> $past(done));

   // Parity and framing flags hold until their own strobe.
   p_par_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_par && !clr_par) |=> err_par);

   p_frm_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_frm && !clr_frm) |=> err_frm);

   p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (err_ovr && !clr_ovr) |=> err_ovr);

endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
   parameter int OVERSAMPLE  = 16,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              rxd,
   input  logic              cfg_short_char,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_two_stop,
   input  logic              irq_en,
   input  logic              clr_full,
   input  logic              clr_overrun,
   input  logic              clr_framing,
   input  logic              clr_parity,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              err_overrun,
   output logic              err_framing,
   output logic              err_parity,
   output logic              irq_rx_full,
   output logic              irq_rx_err
);

   generate
      if (OVERSAMPLE < 4 || (OVERSAMPLE % 2) != 0) begin : g_bad_os
         $error("serial_rx_core: OVERSAMPLE must be even and at least 4");
      end
      if (DATA_W < 5) begin : g_bad_w
         $error("serial_rx_core: DATA_W must be at least 5");
      end
   endgenerate

   logic              line_s;
   logic              done;
   logic [DATA_W-1:0] shreg;
   logic              par_bit;
   logic              stop_bit;
   logic              err_any;

   srx_line_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rxd),
      .dout  (line_s)
   );

   srx_frame_fsm #(
      .OVERSAMPLE (OVERSAMPLE),
      .DATA_W     (DATA_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .tick         (samp_en),
      .line         (line_s),
      .hold         (err_any),
      .cfg_short    (cfg_short_char),
      .cfg_par_en   (cfg_par_en),
      .cfg_two_stop (cfg_two_stop),
      .done         (done),
      .shreg        (shreg),
      .par_bit      (par_bit),
      .stop_bit     (stop_bit)
   );

   srx_status_regs #(
      .DATA_W (DATA_W)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .done        (done),
      .data_in     (shreg),
      .par_bit     (par_bit),
      .stop_bit    (stop_bit),
      .cfg_short   (cfg_short_char),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .irq_en      (irq_en),
      .clr_full    (clr_full),
      .clr_ovr     (clr_overrun),
      .clr_frm     (clr_framing),
      .clr_par     (clr_parity),
      .rx_data     (rx_data),
      .rx_full     (rx_full),
      .err_ovr     (err_overrun),
      .err_frm     (err_framing),
      .err_par     (err_parity),
      .err_any     (err_any),
      .irq_full    (irq_rx_full),
      .irq_err     (irq_rx_err)
   );

   // Both requests are gated by the single enable.
   p_irq_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_rx_full || irq_rx_err) |-> irq_en);

endmodule

// File: tb/serial_rx_core_bench.sv
module serial_rx_core_bench;

   localparam int OS     = 16;
   localparam int BITCLK = 2 * OS;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp_en = 1'b0;
   logic       rxd = 1'b1;
   logic       cfg_short_char = 1'b0;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       cfg_two_stop = 1'b0;
   logic       irq_en = 1'b0;
   logic       clr_full = 1'b0;
   logic       clr_overrun = 1'b0;
   logic       clr_framing = 1'b0;
   logic       clr_parity = 1'b0;
   logic [7:0] rx_data;
   logic       rx_full, err_overrun, err_framing, err_parity;
   logic       irq_rx_full, irq_rx_err;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   always @(posedge clk) samp_en <= rst_n ? ~samp_en : 1'b0;

   serial_rx_core #(
      .OVERSAMPLE  (OS),
      .DATA_W      (8),
      .SYNC_STAGES (2)
   ) u_serial_rx_core (
      .clk            (clk),
      .rst_n          (rst_n),
      .samp_en        (samp_en),
      .rxd            (rxd),
      .cfg_short_char (cfg_short_char),
      .cfg_par_en     (cfg_par_en),
      .cfg_par_odd    (cfg_par_odd),
      .cfg_two_stop   (cfg_two_stop),
      .irq_en         (irq_en),
      .clr_full       (clr_full),
      .clr_overrun    (clr_overrun),
      .clr_framing    (clr_framing),
      .clr_parity     (clr_parity),
      .rx_data        (rx_data),
      .rx_full        (rx_full),
      .err_overrun    (err_overrun),
      .err_framing    (err_framing),
      .err_parity     (err_parity),
      .irq_rx_full    (irq_rx_full),
      .irq_rx_err     (irq_rx_err)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic drive_bit(input logic v);
      rxd = v;
      repeat (BITCLK) @(negedge clk);
   endtask

   task automatic send_char(input logic [7:0] d, input bit flip_par,
                            input bit s1, input bit s2);
      int  n;
      logic [7:0] dm;
      logic p;
      n  = cfg_short_char ? 7 : 8;
      dm = cfg_short_char ? (d & 8'h7f) : d;
      p  = (^dm) ^ cfg_par_odd ^ flip_par;
      drive_bit(1'b0);
      for (int i = 0; i < n; i++) drive_bit(d[i]);
      if (cfg_par_en) drive_bit(p);
      drive_bit(s1);
      if (cfg_two_stop) drive_bit(s2);
      drive_bit(1'b1);
      drive_bit(1'b1);
   endtask

   task automatic pulse(ref logic sig);
      sig = 1'b1;
      @(negedge clk);
      sig = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R13", "rx_data", rx_data, 0);
      check("R13", "flags", {rx_full, err_overrun, err_framing, err_parity}, 0);
      check("R13", "irqs", {irq_rx_full, irq_rx_err}, 0);
   endtask

   task automatic t_clean();
      irq_en = 1'b1;
      send_char(8'hA5, 0, 1, 1);
      check("R7", "rx_full", rx_full, 1);
      check("R2", "rx_data lsb first", rx_data, 8'hA5);
      check("R8", "irq_rx_full", irq_rx_full, 1);
      check("R9", "irq_rx_err idle", irq_rx_err, 0);
      pulse(clr_full);
      check("R12", "rx_full cleared", rx_full, 0);
      check("R8", "irq_rx_full after clear", irq_rx_full, 0);
   endtask

   task automatic t_glitch();
      rxd = 1'b0;
      repeat (4) @(negedge clk);
      rxd = 1'b1;
      repeat (3 * BITCLK) @(negedge clk);
      check("R1", "glitch flags", {rx_full, err_overrun, err_framing, err_parity}, 0);
      check("R1", "glitch data", rx_data, 8'hA5);
   endtask

   task automatic t_short();
      cfg_short_char = 1'b1;
      send_char(8'hD5, 0, 1, 1);
      check("R2", "short rx_data", rx_data, 8'h55);
      check("R2", "short rx_full", rx_full, 1);
      pulse(clr_full);
      cfg_short_char = 1'b0;
   endtask

   task automatic t_parity();
      cfg_par_en = 1'b1;
      cfg_par_odd = 1'b0;
      send_char(8'h03, 0, 1, 1);
      check("R3", "even good full", rx_full, 1);
      check("R3", "even good no err", err_parity, 0);
      pulse(clr_full);
      cfg_par_odd = 1'b1;
      send_char(8'h07, 0, 1, 1);
      check("R3", "odd good full", rx_full, 1);
      pulse(clr_full);
      send_char(8'h5A, 1, 1, 1);
      check("R3", "bad parity flag", err_parity, 1);
      check("R3", "bad parity data loaded", rx_data, 8'h5A);
      check("R3", "bad parity not full", rx_full, 0);
      check("R9", "irq_rx_err on parity", irq_rx_err, 1);
      pulse(clr_parity);
      check("R10", "parity cleared", err_parity, 0);
      check("R9", "irq_rx_err after clear", irq_rx_err, 0);
      cfg_par_en = 1'b0;
      cfg_par_odd = 1'b0;
   endtask

   task automatic t_framing();
      send_char(8'h66, 0, 0, 1);
      check("R4", "framing flag", err_framing, 1);
      check("R4", "framing data loaded", rx_data, 8'h66);
      check("R4", "framing not full", rx_full, 0);
      send_char(8'h11, 0, 1, 1);
      check("R11", "blocked data", rx_data, 8'h66);
      check("R11", "blocked full", rx_full, 0);
      pulse(clr_overrun);
      check("R10", "framing kept by other strobe", err_framing, 1);
      pulse(clr_framing);
      check("R10", "framing cleared", err_framing, 0);
      send_char(8'h22, 0, 1, 1);
      check("R7", "resume data", rx_data, 8'h22);
      check("R7", "resume full", rx_full, 1);
      pulse(clr_full);
   endtask

   task automatic t_two_stop();
      cfg_two_stop = 1'b1;
      send_char(8'h81, 0, 1, 0);
      check("R5", "second stop ignored full", rx_full, 1);
      check("R5", "second stop ignored frm", err_framing, 0);
      pulse(clr_full);
      send_char(8'h42, 0, 0, 1);
      check("R5", "first stop checked", err_framing, 1);
      pulse(clr_framing);
      cfg_two_stop = 1'b0;
   endtask

   task automatic t_overrun();
      send_char(8'h12, 0, 1, 1);
      send_char(8'h34, 0, 1, 1);
      check("R6", "overrun flag", err_overrun, 1);
      check("R6", "overrun keeps data", rx_data, 8'h12);
      check("R6", "overrun full stays", rx_full, 1);
      check("R9", "irq_rx_err overrun", irq_rx_err, 1);
      pulse(clr_overrun);
      check("R10", "overrun cleared", err_overrun, 0);
      pulse(clr_full);
   endtask

   task automatic t_irq_off();
      irq_en = 1'b0;
      send_char(8'h99, 0, 1, 1);
      check("R8", "full with irq off", rx_full, 1);
      check("R8", "irq_rx_full gated", irq_rx_full, 0);
      pulse(clr_full);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean();
      t_glitch();
      t_short();
      t_parity();
      t_framing();
      t_two_stop();
      t_overrun();
      t_irq_off();
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule